// File: doc/BRIEF.md
# PS/2 Host Port Register Block

This block is the processor-facing register set for one PS/2 keyboard or mouse port. A processor reaches it through a simple word-addressed bus. A device-side receiver hands it finished bytes through a valid/byte pair. The block holds the newest byte until software reads the data register. A write to the data register sends a byte, with a one-cycle strobe, to a device-side transmitter. Line-level serial framing, line clock generation and device behaviour are handled elsewhere.

Software sees five registers: control, status, data, clock divisor and interrupt status. A read-only identification window sits at the top of a 4 KB region. Status reports whether a byte is waiting and the parity of the byte most recently taken by software. The transmitter is always reported empty. One interrupt line combines a receive term, gated by a control enable, with a transmit-enable term that does not depend on any event.

Top module: `ps2_host_port`

## Requirements
- R1: After reset, control, divisor and the last-read byte are zero and no byte is pending. Status reads 0x40, interrupt status reads 0x2, data reads 0, `irq` is 0 and `tx_valid` is 0.
- R2: Control (offset 0x00) and divisor (offset 0x0C) store the low CTRL_W and DIV_W bits of a write, 8 each by default. They read back those bits with the upper bits zero, and a write has no other effect.
- R3: A cycle with `rx_valid` high stores `rx_byte` as the held byte and sets pending. While a byte is pending, status bit 4 reads 1.
- R4: A read of data (offset 0x08) while a byte is pending returns the held byte, copies it into the last-read byte and clears pending. A read with nothing pending returns the last-read byte and changes nothing.
- R5: `rx_valid` while a byte is already pending replaces the held byte and leaves pending set. If it coincides with a data read, the read returns and consumes the old byte, and the new byte stays pending.
- R6: Status (offset 0x04) has bit 6 always 1, bits 5, 3, 1 and 0 always 0, and bit 2 equal to the XOR of the eight bits of the last-read byte.
- R7: Interrupt status (offset 0x10) reads pending in bit 0 and a constant 1 in bit 1.
- R8: `irq` is high exactly when control bit 3 is set, or control bit 4 is set and a byte is pending. It takes its new value in the cycle after a control write.
- R9: A write to data sets `tx_byte` to write-data bits 7:0 and raises `tx_valid` for exactly the next cycle.
- R10: Reads from 0xFE0 through 0xFFC return, one byte per word in ascending address order, 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: Any other word offset reads as 0, and a write to it changes no register and emits no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address; bits 1:0 ignored |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid in the cycle of the access |
| rx_valid | input | 1 | Receiver presents a finished byte |
| rx_byte | input | 8 | Received byte |
| tx_valid | output | 1 | One-cycle strobe for a byte to send |
| tx_byte | output | 8 | Byte to send |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default parameters: a 12-bit address, a 32-bit bus and 8-bit control and divisor fields. At these sizes every one of the 256 byte values can be passed through receive, consume and parity, and every divisor and control value can be read back. Every word offset in the 4 KB region can be probed for read-as-zero and ignored writes, and all four combinations of the two interrupt enables can be tried with and without a pending byte.

// File: rtl/ps2h_pkg.sv
package ps2h_pkg;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_STAT = 3'd1,
    SEL_DATA = 3'd2,
    SEL_DIV  = 3'd3,
    SEL_INTR = 3'd4,
    SEL_ID   = 3'd5,
    SEL_NONE = 3'd6
  } reg_sel_e;

  localparam int unsigned BIT_TX_EMPTY = 6;
  localparam int unsigned BIT_RX_FULL  = 4;
  localparam int unsigned BIT_RX_PAR   = 2;
  localparam int unsigned BIT_IRQ_RXEN = 4;
  localparam int unsigned BIT_IRQ_TXEN = 3;

  // even-weight check: 1 when the byte holds an odd number of ones
  function automatic logic byte_parity(input logic [7:0] b);
    return ^b;
  endfunction

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h50;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/ps2h_decode.sv
module ps2h_decode
  import ps2h_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [2:0]        id_idx
);
  localparam int unsigned WORD_W  = ADDR_W - 2;
  localparam int unsigned ID_BASE = (1 << WORD_W) - 8;

  logic [WORD_W-1:0] word;
  logic [1:0]        unused_addr_lo;

  assign word           = addr[ADDR_W-1:2];
  assign unused_addr_lo = addr[1:0];
  assign id_idx         = word[2:0];

  always_comb begin
    if (32'(word) >= ID_BASE) sel = SEL_ID;
    else begin
      case (32'(word))
        0:       sel = SEL_CTRL;
        1:       sel = SEL_STAT;
        2:       sel = SEL_DATA;
        3:       sel = SEL_DIV;
        4:       sel = SEL_INTR;
        default: sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ps2h_rx_hold.sv
module ps2h_rx_hold (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       consume,
  output logic       pending,
  output logic [7:0] held,
  output logic [7:0] last
);
  logic take;
  assign take = consume && pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      held    <= '0;
      last    <= '0;
    end else begin
      if (take) last <= held;
      if (rx_valid) begin
        held    <= rx_byte;
        pending <= 1'b1;
      end else if (take) begin
        pending <= 1'b0;
      end
    end
  end

  a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> pending && held == $past(rx_byte));
  a_r4_consume: assert property (@(posedge clk) disable iff (!rst_n)
    consume && pending && !rx_valid |=> !pending && last == $past(held));
  a_r4_stale: assert property (@(posedge clk) disable iff (!rst_n)
    !(consume && pending) |=> $stable(last));
  a_r5_keep: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !consume |=> pending);
endmodule

// File: rtl/ps2h_csr.sv
module ps2h_csr #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CTRL_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              div_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl,
  output logic [DIV_W-1:0]  div
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      div  <= '0;
    end else begin
      if (ctrl_we) ctrl <= wdata[CTRL_W-1:0];
      if (div_we)  div  <= wdata[DIV_W-1:0];
    end
  end

  a_r2_ctrl_store: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> ctrl == $past(wdata[CTRL_W-1:0]));
  a_r2_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !div_we |=> $stable(div));
endmodule

// File: rtl/ps2h_tx_emit.sv
module ps2h_tx_emit #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_we,
  input  logic [DATA_W-1:0] wdata,
  output logic              tx_valid,
  output logic [7:0]        tx_byte
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tx_valid <= data_we;
      if (data_we) tx_byte <= wdata[7:0];
    end
  end

  a_r9_pulse_src: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(data_we));
  a_r9_byte: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |=> tx_valid && tx_byte == $past(wdata[7:0]));
endmodule

// File: rtl/ps2_host_port.sv
module ps2_host_port
  import ps2h_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CTRL_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  output logic              irq
);
  reg_sel_e          sel;
  logic [2:0]        id_idx;
  logic              wr_hit, rd_hit;
  logic              ctrl_we, div_we, data_we, consume;
  logic              pending;
  logic [7:0]        held, last;
  logic [CTRL_W-1:0] ctrl;
  logic [DIV_W-1:0]  div;
  logic              rx_irq_en, tx_irq_en;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata;

  ps2h_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .sel(sel), .id_idx(id_idx)
  );

  assign wr_hit  = bus_sel &&  bus_we;
  assign rd_hit  = bus_sel && !bus_we;
  assign ctrl_we = wr_hit && sel == SEL_CTRL;
  assign div_we  = wr_hit && sel == SEL_DIV;
  assign data_we = wr_hit && sel == SEL_DATA;
  assign consume = rd_hit && sel == SEL_DATA;

  ps2h_rx_hold u_rx (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .consume(consume), .pending(pending), .held(held), .last(last)
  );

  ps2h_csr #(.DATA_W(DATA_W), .CTRL_W(CTRL_W), .DIV_W(DIV_W)) u_csr (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .div_we(div_we),
    .wdata(bus_wdata), .ctrl(ctrl), .div(div)
  );

  ps2h_tx_emit #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .data_we(data_we), .wdata(bus_wdata),
    .tx_valid(tx_valid), .tx_byte(tx_byte)
  );

  assign rx_irq_en = ctrl[BIT_IRQ_RXEN];
  assign tx_irq_en = ctrl[BIT_IRQ_TXEN];
  assign irq       = tx_irq_en || (rx_irq_en && pending);

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_CTRL: bus_rdata[CTRL_W-1:0] = ctrl;
      SEL_STAT: begin
        bus_rdata[BIT_TX_EMPTY] = 1'b1;
        bus_rdata[BIT_RX_FULL]  = pending;
        bus_rdata[BIT_RX_PAR]   = byte_parity(last);
      end
      SEL_DATA: bus_rdata[7:0] = pending ? held : last;
      SEL_DIV:  bus_rdata[DIV_W-1:0] = div;
      SEL_INTR: bus_rdata[1:0] = {1'b1, pending};
      SEL_ID:   bus_rdata[7:0] = id_byte(id_idx);
      default:  bus_rdata = '0;
    endcase
  end

  a_r8_follow: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> irq == ($past(bus_wdata[BIT_IRQ_TXEN])
                        || ($past(bus_wdata[BIT_IRQ_RXEN]) && pending)));
  a_r11_undef_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit && sel == SEL_NONE |=> $stable(ctrl) && $stable(div) && !tx_valid);
  a_r11_undef_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit && sel == SEL_NONE |-> bus_rdata == '0);
  a_r6_tx_empty: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit && sel == SEL_STAT |-> bus_rdata[BIT_TX_EMPTY]);
endmodule

// File: tb/ps2_host_port_tb.sv
`timescale 1ns/1ps
module ps2_host_port_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 0;
  logic [7:0]  rx_byte = '0;
  logic        tx_valid;
  logic [7:0]  tx_byte;
  logic        irq;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  ps2_host_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .irq(irq)
  );

  // bench-side model state
  logic       m_pend;
  logic [7:0] m_held, m_last;

  function automatic logic odd_ones(input logic [7:0] b);
    int c = 0;
    for (int i = 0; i < 8; i++) c += b[i];
    return (c % 2) == 1;
  endfunction

  function automatic logic [31:0] exp_stat();
    return 32'h40 + (m_pend ? 32'h10 : 0) + (odd_ones(m_last) ? 32'h4 : 0);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 v = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 0;
    if (a == 12'h008 && m_pend) begin m_last = m_held; m_pend = 0; end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_byte = b;
    @(posedge clk); #1;
    rx_valid = 0;
    m_held = b; m_pend = 1;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    m_pend = 0; m_held = 0; m_last = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    rd(12'h000, v); chk("R1 ctrl", v, 0);
    rd(12'h00C, v); chk("R1 div", v, 0);
    rd(12'h004, v); chk("R1 stat", v, 32'h40);
    rd(12'h010, v); chk("R1 intr", v, 32'h2);
    rd(12'h008, v); chk("R1 data", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 tx_valid", tx_valid, 0);

    // R2 storage sweep
    for (int i = 0; i < 256; i++) begin
      wr(12'h00C, 32'hABCD_0000 | i);
      rd(12'h00C, v); chk("R2 div", v, i);
    end
    wr(12'h000, 32'hFFFF_FF27);
    rd(12'h000, v); chk("R2 ctrl", v, 32'h27);
    wr(12'h000, 0);

    // R3 R4 R6 R7: every byte value through receive and consume
    for (int b = 0; b < 256; b++) begin
      push(8'(b));
      rd(12'h004, v); chk("R3 R6 stat pending", v, exp_stat());
      rd(12'h010, v); chk("R7 intr pending", v, 32'h3);
      rd(12'h008, v); chk("R4 data consume", v, b);
      rd(12'h004, v); chk("R6 parity of last", v, exp_stat());
      rd(12'h008, v); chk("R4 data stale", v, b);
      rd(12'h010, v); chk("R7 intr idle", v, 32'h2);
    end

    // R5 overwrite while pending
    push(8'h11); push(8'h22);
    rd(12'h008, v); chk("R5 overwrite", v, 32'h22);
    // R5 arrival coinciding with a consuming read
    push(8'h33);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = 12'h008; rx_valid = 1; rx_byte = 8'h44;
    #1 chk("R5 coincident old byte", bus_rdata, 32'h33);
    @(posedge clk); #1;
    bus_sel = 0; rx_valid = 0;
    m_last = 8'h33; m_held = 8'h44; m_pend = 1;
    rd(12'h004, v); chk("R5 still pending", v, exp_stat());
    rd(12'h008, v); chk("R5 new byte", v, 32'h44);

    // R8 interrupt: enables x pending
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 4; c++) begin
        if (p == 1 && !m_pend) push(8'h5A);
        wr(12'h000, (c & 1 ? 32'h08 : 0) | (c & 2 ? 32'h10 : 0));
        chk("R8 irq", irq, ((c & 1) != 0) || (((c & 2) != 0) && p == 1));
      end
    end
    wr(12'h000, 32'h10);
    chk("R8 irq rx pending", irq, 1);
    rd(12'h008, v);
    #1 chk("R8 irq drops after consume", irq, 0);
    wr(12'h000, 0);

    // R9 transmit strobe
    for (int t = 0; t < 256; t += 37) begin
      wr(12'h008, 32'h1234_5600 | t);
      chk("R9 tx_valid", tx_valid, 1);
      chk("R9 tx_byte", tx_byte, t);
      @(posedge clk); #1;
      chk("R9 single pulse", tx_valid, 0);
    end

    // R10 identification window
    for (int k = 0; k < 8; k++) begin
      logic [7:0] e;
      case (k)
        0: e = 8'h50; 1: e = 8'h10; 2: e = 8'h04; 3: e = 8'h00;
        4: e = 8'h0D; 5: e = 8'hF0; 6: e = 8'h05; default: e = 8'hB1;
      endcase
      rd(12'hFE0 + 12'(k * 4), v); chk("R10 id", v, e);
    end

    // R11 undefined offsets
    wr(12'h000, 32'h5C); wr(12'h00C, 32'hA3);
    for (int w = 5; w < 1016; w++) begin
      wr(12'(w * 4), 32'hFFFF_FFFF);
      chk("R11 no tx", tx_valid, 0);
      rd(12'(w * 4), v); chk("R11 read zero", v, 0);
    end
    rd(12'h000, v); chk("R11 ctrl kept", v, 32'h5C);
    rd(12'h00C, v); chk("R11 div kept", v, 32'hA3);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule